// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the control unit of a 16-bit load/store processor in which every register and the memory interface share one internal bus. It holds the machine state and, in every clock cycle, drives the full set of datapath controls: register load enables, the bus gate that picks the one source allowed on the bus, the multiplexer selects of the PC, address adder, register file and MDR, the ALU operation, and the memory enable and write strobe.

Each instruction goes through three fetch cycles, one decode cycle with no enables, and then an execute sequence chosen by the opcode in IR bits 15..12. The schedule respects two limits of the datapath. A register written in one cycle can only be used in the next. Only one value can travel on the bus per cycle. Because of this, a memory access always comes one cycle after the register that feeds it is loaded. After the last execute cycle the sequencer goes back to the first fetch cycle. The branch decision is made outside the block and comes in on `ben`.

Opcode map (IR[15:12]): 0000 branch, 0001 add, 0010 PC-relative load, 0011 PC-relative store, 0100 subroutine call, 0101 and, 0110 base+offset load, 0111 base+offset store, 1001 not, 1010 indirect load, 1011 indirect store, 1100 register jump, 1110 effective-address load. The codes 1000, 1101 and 1111 are not implemented.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst_n` is low every output is 0. The first cycle after release is fetch cycle 1.
- R2: Fetch runs over three cycles. Cycle 1: `gate_pc`, `ld_mar` and `ld_pc` with `pc_sel`=00 (increment). Cycle 2: `mem_en`, `ld_mdr` and `mdr_from_mem`. Cycle 3: `gate_mdr` and `ld_ir`. Then comes one decode cycle in which every output is 0.
- R3: At most one of `gate_pc`, `gate_mdr`, `gate_alu`, `gate_adr` is 1 in any cycle.
- R4: A memory read happens only in the cycle after an `ld_mar`. A memory write (`mem_en` and `mem_we`) happens only in the cycle after an `ld_mdr`.
- R5: Add (0001), and (0101) and not (1001) each execute in one cycle with `gate_alu`, `ld_reg`, `ld_cc` and `src1_base`. The `alu_op` is 00 for add, 01 for and, 10 for not. `sr2_imm` follows IR[5] for add and and, and is 0 for not.
- R6: Loads 0010 and 0110 take three execute cycles: address into MAR (`gate_adr`, `ld_mar`), memory into MDR, then `gate_mdr` with `ld_reg` and `ld_cc`. Load 1010 takes five cycles: after the first read it gates MDR into MAR and reads again.
- R7: Stores 0011 and 0111 take three execute cycles: address into MAR, then `gate_alu` with `alu_op`=11 and `ld_mdr` with `mdr_from_mem`=0, then `mem_en` with `mem_we`. Store 1011 adds the same indirect pair of cycles, for five in total. No store cycle ever asserts `ld_cc`.
- R8: Address selects. PC-relative forms use `adr1_sel`=0 and `adr2_sel`=10 (9-bit offset). Base+offset forms use `adr1_sel`=1, `adr2_sel`=01 (6-bit offset) and `src1_base`=1.
- R9: Effective-address load (1110) takes one cycle: `gate_adr` and `ld_reg` with PC-relative selects, and `ld_cc` stays 0.
- R10: Branch (0000) takes one cycle with PC-relative selects and `pc_sel`=10 (adder). `ld_pc` equals `ben`.
- R11: Register jump (1100) takes one cycle: `src1_base`, `adr1_sel`=1, `adr2_sel`=00 (zero), `pc_sel`=10 and `ld_pc`.
- R12: Call (0100) takes one cycle with `gate_pc`, `ld_reg`, `dst_r7`, `pc_sel`=10 and `ld_pc`. If IR[11]=1 the target is PC plus an 11-bit offset (`adr1_sel`=0, `adr2_sel`=11). If IR[11]=0 the target is the base register (`src1_base`, `adr1_sel`=1, `adr2_sel`=00).
- R13: The codes 1000, 1101 and 1111 go from decode straight back to fetch cycle 1, with no execute cycle.
- R14: Any output not named for a cycle is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 16 | Instruction register contents |
| ben | input | 1 | Branch condition met |
| ld_pc | output | 1 | Load PC |
| ld_mar | output | 1 | Load memory address register |
| ld_mdr | output | 1 | Load memory data register |
| ld_ir | output | 1 | Load instruction register |
| ld_reg | output | 1 | Write register file |
| ld_cc | output | 1 | Load condition codes |
| gate_pc | output | 1 | Drive PC onto bus |
| gate_mdr | output | 1 | Drive MDR onto bus |
| gate_alu | output | 1 | Drive ALU result onto bus |
| gate_adr | output | 1 | Drive address adder onto bus |
| pc_sel | output | 2 | PC source: 00 increment, 01 bus, 10 adder |
| adr1_sel | output | 1 | Adder base: 0 PC, 1 base register |
| adr2_sel | output | 2 | Adder offset: 00 zero, 01 IR[5:0], 10 IR[8:0], 11 IR[10:0], sign-extended |
| dst_r7 | output | 1 | Destination forced to register 7 |
| src1_base | output | 1 | First read port: 1 IR[8:6], 0 IR[11:9] |
| sr2_imm | output | 1 | ALU operand 2 from immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 and, 10 not, 11 pass |
| mdr_from_mem | output | 1 | MDR loads memory (1) or bus (0) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write |

## Verification
The bench compares the whole control word on every cycle of every instruction, so it catches a cycle in the wrong place, a sequence of the wrong length, or a stray enable. The critical cases are the indirect load and store, where a design that skips the MDR-to-MAR transfer reads the pointer cell as data. Branches with `ben` low are tested, where a design that always loads PC takes every branch. Both call forms are tested, because a swapped IR[11] test takes the wrong target. The unimplemented codes are tested, where a design that falls into an execute state sits out of step with the fetch. Add and and are run with both IR[5] values, and stores are checked for a stray `ld_cc`, which would corrupt the flags.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

   typedef enum logic [3:0] {
      ST_F1, ST_F2, ST_F3, ST_DEC,
      ST_ALU, ST_LEA, ST_BR, ST_JMP, ST_JSR,
      ST_ADR, ST_IRD, ST_IMV, ST_RD, ST_WB, ST_SD, ST_WR
   } state_e;

   typedef enum logic [2:0] {
      K_NONE, K_ALU, K_LEA, K_BR, K_JMP, K_JSR, K_LOAD, K_STORE
   } kind_e;

   localparam logic [3:0] OPC_BR  = 4'h0;
   localparam logic [3:0] OPC_ADD = 4'h1;
   localparam logic [3:0] OPC_LD  = 4'h2;
   localparam logic [3:0] OPC_ST  = 4'h3;
   localparam logic [3:0] OPC_JSR = 4'h4;
   localparam logic [3:0] OPC_AND = 4'h5;
   localparam logic [3:0] OPC_LDR = 4'h6;
   localparam logic [3:0] OPC_STR = 4'h7;
   localparam logic [3:0] OPC_NOT = 4'h9;
   localparam logic [3:0] OPC_LDI = 4'hA;
   localparam logic [3:0] OPC_STI = 4'hB;
   localparam logic [3:0] OPC_JMP = 4'hC;
   localparam logic [3:0] OPC_LEA = 4'hE;

   localparam logic [1:0] PCS_INC = 2'b00;
   localparam logic [1:0] PCS_ADD = 2'b10;
   localparam logic [1:0] A2_ZERO = 2'b00;
   localparam logic [1:0] A2_OFF6 = 2'b01;
   localparam logic [1:0] A2_OFF9 = 2'b10;
   localparam logic [1:0] A2_OFF11 = 2'b11;
   localparam logic [1:0] ALU_ADD = 2'b00;
   localparam logic [1:0] ALU_AND = 2'b01;
   localparam logic [1:0] ALU_NOT = 2'b10;
   localparam logic [1:0] ALU_PASS = 2'b11;

   typedef struct packed {
      logic       ld_pc;
      logic       ld_mar;
      logic       ld_mdr;
      logic       ld_ir;
      logic       ld_reg;
      logic       ld_cc;
      logic       gate_pc;
      logic       gate_mdr;
      logic       gate_alu;
      logic       gate_adr;
      logic [1:0] pc_sel;
      logic       adr1_sel;
      logic [1:0] adr2_sel;
      logic       dst_r7;
      logic       src1_base;
      logic       sr2_imm;
      logic [1:0] alu_op;
      logic       mdr_from_mem;
      logic       mem_en;
      logic       mem_we;
   } ctl_t;

endpackage

// File: rtl/ctl_seq_decode.sv
module ctl_seq_decode
   import ctl_seq_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic [OPC_W-1:0] opc,
   output kind_e            kind,
   output logic             indirect,
   output logic             base_addr
);
   always_comb begin
      kind      = K_NONE;
      indirect  = 1'b0;
      base_addr = 1'b0;
      unique case (opc)
         OPC_ADD, OPC_AND, OPC_NOT: kind = K_ALU;
         OPC_LEA: kind = K_LEA;
         OPC_BR:  kind = K_BR;
         OPC_JMP: kind = K_JMP;
         OPC_JSR: kind = K_JSR;
         OPC_LD:  kind = K_LOAD;
         OPC_LDR: begin kind = K_LOAD; base_addr = 1'b1; end
         OPC_LDI: begin kind = K_LOAD; indirect = 1'b1; end
         OPC_ST:  kind = K_STORE;
         OPC_STR: begin kind = K_STORE; base_addr = 1'b1; end
         OPC_STI: begin kind = K_STORE; indirect = 1'b1; end
         default: kind = K_NONE;
      endcase
   end
endmodule

// File: rtl/ctl_seq_next.sv
module ctl_seq_next
   import ctl_seq_pkg::*;
(
   input  state_e cur,
   input  kind_e  kind,
   input  logic   indirect,
   output state_e nxt
);
   state_e entry;

   always_comb begin
      unique case (kind)
         K_ALU:   entry = ST_ALU;
         K_LEA:   entry = ST_LEA;
         K_BR:    entry = ST_BR;
         K_JMP:   entry = ST_JMP;
         K_JSR:   entry = ST_JSR;
         K_LOAD,
         K_STORE: entry = ST_ADR;
         default: entry = ST_F1;
      endcase
   end

   always_comb begin
      unique case (cur)
         ST_F1:  nxt = ST_F2;
         ST_F2:  nxt = ST_F3;
         ST_F3:  nxt = ST_DEC;
         ST_DEC: nxt = entry;
         ST_ADR: begin
            if (indirect)           nxt = ST_IRD;
            else if (kind == K_LOAD) nxt = ST_RD;
            else                     nxt = ST_SD;
         end
         ST_IRD: nxt = ST_IMV;
         ST_IMV: nxt = (kind == K_LOAD) ? ST_RD : ST_SD;
         ST_RD:  nxt = ST_WB;
         ST_SD:  nxt = ST_WR;
         default: nxt = ST_F1;
      endcase
   end
endmodule

// File: rtl/ctl_seq_word.sv
module ctl_seq_word
   import ctl_seq_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  state_e           cur,
   input  logic [OPC_W-1:0] opc,
   input  logic             base_addr,
   input  logic             ir_bit11,
   input  logic             ir_bit5,
   input  logic             ben,
   output ctl_t             word
);
   always_comb begin
      word = '0;
      unique case (cur)
         ST_F1: begin
            word.gate_pc = 1'b1;
            word.ld_mar  = 1'b1;
            word.ld_pc   = 1'b1;
            word.pc_sel  = PCS_INC;
         end
         ST_F2, ST_IRD, ST_RD: begin
            word.mem_en       = 1'b1;
            word.ld_mdr       = 1'b1;
            word.mdr_from_mem = 1'b1;
         end
         ST_F3: begin
            word.gate_mdr = 1'b1;
            word.ld_ir    = 1'b1;
         end
         ST_ALU: begin
            word.gate_alu  = 1'b1;
            word.ld_reg    = 1'b1;
            word.ld_cc     = 1'b1;
            word.src1_base = 1'b1;
            if (opc == OPC_NOT) begin
               word.alu_op = ALU_NOT;
            end else begin
               word.alu_op  = (opc == OPC_AND) ? ALU_AND : ALU_ADD;
               word.sr2_imm = ir_bit5;
            end
         end
         ST_LEA: begin
            word.gate_adr = 1'b1;
            word.ld_reg   = 1'b1;
            word.adr2_sel = A2_OFF9;
         end
         ST_BR: begin
            word.adr2_sel = A2_OFF9;
            word.pc_sel   = PCS_ADD;
            word.ld_pc    = ben;
         end
         ST_JMP: begin
            word.src1_base = 1'b1;
            word.adr1_sel  = 1'b1;
            word.adr2_sel  = A2_ZERO;
            word.pc_sel    = PCS_ADD;
            word.ld_pc     = 1'b1;
         end
         ST_JSR: begin
            word.gate_pc = 1'b1;
            word.ld_reg  = 1'b1;
            word.dst_r7  = 1'b1;
            word.pc_sel  = PCS_ADD;
            word.ld_pc   = 1'b1;
            if (ir_bit11) begin
               word.adr2_sel = A2_OFF11;
            end else begin
               word.src1_base = 1'b1;
               word.adr1_sel  = 1'b1;
            end
         end
         ST_ADR: begin
            word.gate_adr = 1'b1;
            word.ld_mar   = 1'b1;
            if (base_addr) begin
               word.src1_base = 1'b1;
               word.adr1_sel  = 1'b1;
               word.adr2_sel  = A2_OFF6;
            end else begin
               word.adr2_sel = A2_OFF9;
            end
         end
         ST_IMV: begin
            word.gate_mdr = 1'b1;
            word.ld_mar   = 1'b1;
         end
         ST_WB: begin
            word.gate_mdr = 1'b1;
            word.ld_reg   = 1'b1;
            word.ld_cc    = 1'b1;
         end
         ST_SD: begin
            word.gate_alu = 1'b1;
            word.alu_op   = ALU_PASS;
            word.ld_mdr   = 1'b1;
         end
         ST_WR: begin
            word.mem_en = 1'b1;
            word.mem_we = 1'b1;
         end
         default: word = '0;
      endcase
   end
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
   import ctl_seq_pkg::*;
#(
   parameter int IR_W    = 16,
   parameter int OPC_W   = 4,
   parameter int ALU_W   = 2,
   parameter int PCSEL_W = 2,
   parameter int ADR2_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IR_W-1:0]    ir,
   input  logic               ben,
   output logic               ld_pc,
   output logic               ld_mar,
   output logic               ld_mdr,
   output logic               ld_ir,
   output logic               ld_reg,
   output logic               ld_cc,
   output logic               gate_pc,
   output logic               gate_mdr,
   output logic               gate_alu,
   output logic               gate_adr,
   output logic [PCSEL_W-1:0] pc_sel,
   output logic               adr1_sel,
   output logic [ADR2_W-1:0]  adr2_sel,
   output logic               dst_r7,
   output logic               src1_base,
   output logic               sr2_imm,
   output logic [ALU_W-1:0]   alu_op,
   output logic               mdr_from_mem,
   output logic               mem_en,
   output logic               mem_we
);
   localparam int OPC_LSB = IR_W - OPC_W;

   generate
      if (IR_W != 16) begin : g_bad_ir
         $error("ctl_sequencer: IR_W must be 16");
      end
      if (OPC_W != 4) begin : g_bad_opc
         $error("ctl_sequencer: OPC_W must be 4");
      end
      if (ALU_W != 2 || PCSEL_W != 2 || ADR2_W != 2) begin : g_bad_sel
         $error("ctl_sequencer: select widths must be 2");
      end
   endgenerate

   state_e           cur, nxt;
   kind_e            kind;
   logic             indirect, base_addr;
   ctl_t             word, out_w;
   logic [OPC_W-1:0] opc;

   assign opc = ir[IR_W-1:OPC_LSB];

   ctl_seq_decode #(.OPC_W(OPC_W)) u_dec (
      .opc(opc), .kind(kind), .indirect(indirect), .base_addr(base_addr)
   );

   ctl_seq_next u_next (
      .cur(cur), .kind(kind), .indirect(indirect), .nxt(nxt)
   );

   ctl_seq_word #(.OPC_W(OPC_W)) u_word (
      .cur(cur), .opc(opc), .base_addr(base_addr), .ir_bit11(ir[11]),
      .ir_bit5(ir[5]), .ben(ben), .word(word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= ST_F1;
      else        cur <= nxt;
   end

   assign out_w = rst_n ? word : '0;

   assign ld_pc        = out_w.ld_pc;
   assign ld_mar       = out_w.ld_mar;
   assign ld_mdr       = out_w.ld_mdr;
   assign ld_ir        = out_w.ld_ir;
   assign ld_reg       = out_w.ld_reg;
   assign ld_cc        = out_w.ld_cc;
   assign gate_pc      = out_w.gate_pc;
   assign gate_mdr     = out_w.gate_mdr;
   assign gate_alu     = out_w.gate_alu;
   assign gate_adr     = out_w.gate_adr;
   assign pc_sel       = out_w.pc_sel;
   assign adr1_sel     = out_w.adr1_sel;
   assign adr2_sel     = out_w.adr2_sel;
   assign dst_r7       = out_w.dst_r7;
   assign src1_base    = out_w.src1_base;
   assign sr2_imm      = out_w.sr2_imm;
   assign alu_op       = out_w.alu_op;
   assign mdr_from_mem = out_w.mdr_from_mem;
   assign mem_en       = out_w.mem_en;
   assign mem_we       = out_w.mem_we;

   // Bus ownership: never two drivers
   assert_one_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gate_pc, gate_mdr, gate_alu, gate_adr}));

   // Read uses an address latched one cycle earlier
   assert_read_after_mar_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |-> $past(ld_mar));

   // Write uses data latched one cycle earlier
   assert_write_after_mdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> $past(ld_mdr));

   // Store cycles leave condition codes alone
   assert_store_no_cc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !ld_cc);

   // IR load follows the fetch read
   assert_ir_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ir |-> $past(mem_en && ld_mdr && mdr_from_mem));

   // Register file writes take their value from the bus
   assert_reg_has_source_R14: assert property (@(posedge clk) disable iff (!rst_n)
      ld_reg |-> (gate_pc || gate_mdr || gate_alu || gate_adr));
endmodule

// File: tb/ctl_sequencer_tb.sv
module ctl_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ir = '0;
   logic        ben = 1'b0;
   logic ld_pc, ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc;
   logic gate_pc, gate_mdr, gate_alu, gate_adr;
   logic [1:0] pc_sel, adr2_sel, alu_op;
   logic adr1_sel, dst_r7, src1_base, sr2_imm, mdr_from_mem, mem_en, mem_we;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   ctl_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .ir(ir), .ben(ben),
      .ld_pc(ld_pc), .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir),
      .ld_reg(ld_reg), .ld_cc(ld_cc), .gate_pc(gate_pc), .gate_mdr(gate_mdr),
      .gate_alu(gate_alu), .gate_adr(gate_adr), .pc_sel(pc_sel),
      .adr1_sel(adr1_sel), .adr2_sel(adr2_sel), .dst_r7(dst_r7),
      .src1_base(src1_base), .sr2_imm(sr2_imm), .alu_op(alu_op),
      .mdr_from_mem(mdr_from_mem), .mem_en(mem_en), .mem_we(mem_we)
   );

   function automatic logic [22:0] observed();
      return {ld_pc, ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc,
              gate_pc, gate_mdr, gate_alu, gate_adr, pc_sel, adr1_sel,
              adr2_sel, dst_r7, src1_base, sr2_imm, alu_op,
              mdr_from_mem, mem_en, mem_we};
   endfunction

   // Number of execute cycles per opcode (R5-R13)
   function automatic int exec_len(logic [3:0] op);
      case (op)
         4'h1, 4'h5, 4'h9, 4'hE, 4'h0, 4'hC, 4'h4: return 1;
         4'h2, 4'h6, 4'h3, 4'h7: return 3;
         4'hA, 4'hB: return 5;
         default: return 0;
      endcase
   endfunction

   function automatic string req_of(logic [3:0] op, int step);
      if (step < 4) return "R2";
      case (op)
         4'h1, 4'h5, 4'h9: return "R5";
         4'h2, 4'h6, 4'hA: return "R6";
         4'h3, 4'h7, 4'hB: return "R7";
         4'hE: return "R9";
         4'h0: return "R10";
         4'hC: return "R11";
         4'h4: return "R12";
         default: return "R13";
      endcase
   endfunction

   // Expected control word for step of an instruction (R2, R5-R12, R14)
   function automatic logic [22:0] expect_word(logic [15:0] i, logic b, int step);
      logic p, mar, mdr, li, rg, cc, gp, gm, ga, gd, a1, r7, sb, im, fm, me, we;
      logic [1:0] ps, a2, op;
      logic [3:0] opc;
      int e;
      {p, mar, mdr, li, rg, cc, gp, gm, ga, gd, a1, r7, sb, im, fm, me, we} = '0;
      ps = 2'b00; a2 = 2'b00; op = 2'b00;
      opc = i[15:12];
      e = step - 4;
      if (step == 0) begin gp = 1; mar = 1; p = 1; end
      else if (step == 1) begin me = 1; mdr = 1; fm = 1; end
      else if (step == 2) begin gm = 1; li = 1; end
      else if (step >= 4) begin
         case (opc)
            4'h1, 4'h5, 4'h9: begin
               ga = 1; rg = 1; cc = 1; sb = 1;
               op = (opc == 4'h9) ? 2'b10 : (opc == 4'h5) ? 2'b01 : 2'b00;
               im = (opc == 4'h9) ? 1'b0 : i[5];
            end
            4'hE: begin gd = 1; rg = 1; a2 = 2'b10; end
            4'h0: begin a2 = 2'b10; ps = 2'b10; p = b; end
            4'hC: begin sb = 1; a1 = 1; ps = 2'b10; p = 1; end
            4'h4: begin
               gp = 1; rg = 1; r7 = 1; ps = 2'b10; p = 1;
               if (i[11]) a2 = 2'b11;
               else begin sb = 1; a1 = 1; end
            end
            default: begin
               if (e == 0) begin
                  gd = 1; mar = 1;
                  if (opc == 4'h6 || opc == 4'h7) begin sb = 1; a1 = 1; a2 = 2'b01; end
                  else a2 = 2'b10;
               end else begin
                  int k;
                  k = (opc == 4'hA || opc == 4'hB) ? e : e + 2;
                  if (k == 1) begin me = 1; mdr = 1; fm = 1; end
                  else if (k == 2) begin gm = 1; mar = 1; end
                  else if (opc == 4'h2 || opc == 4'h6 || opc == 4'hA) begin
                     if (k == 3) begin me = 1; mdr = 1; fm = 1; end
                     else begin gm = 1; rg = 1; cc = 1; end
                  end else begin
                     if (k == 3) begin ga = 1; op = 2'b11; mdr = 1; end
                     else begin me = 1; we = 1; end
                  end
               end
            end
         endcase
      end
      return {p, mar, mdr, li, rg, cc, gp, gm, ga, gd, ps, a1, a2, r7, sb, im,
              op, fm, me, we};
   endfunction

   task automatic check_word(string req, logic [22:0] exp_w);
      total++;
      if (observed() !== exp_w) begin
         bad++;
         $display("FAIL %s ir=%h step: actual=%b expected=%b", req, ir, observed(), exp_w);
      end
   endtask

   // One full instruction; called with state in fetch cycle 1 just after a negedge
   task automatic run_instr(logic [15:0] i, logic b);
      int n;
      ir = i; ben = b;
      #1;
      n = 4 + exec_len(i[15:12]);
      for (int s = 0; s < n; s++) begin
         check_word(req_of(i[15:12], s), expect_word(i, b, s));
         @(negedge clk);
         #1;
      end
      // back in fetch cycle 1 (R13 for the no-execute codes)
      check_word((exec_len(i[15:12]) == 0) ? "R13" : "R2", expect_word(i, b, 0));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset drives everything low
      repeat (3) @(negedge clk);
      check_word("R1", '0);
      ir = 16'h1234;
      #2;
      check_word("R1", '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_word("R1", expect_word(16'h0, 1'b0, 0));
      // directed corner cases
      run_instr(16'h1042, 1'b0);   // add register (R5)
      run_instr(16'h1063, 1'b0);   // add immediate (R5)
      run_instr(16'h5020, 1'b0);   // and immediate (R5)
      run_instr(16'h5001, 1'b0);   // and register (R5)
      run_instr(16'h907F, 1'b0);   // not with IR[5]=1 (R5)
      run_instr(16'h0400, 1'b0);   // branch not taken (R10)
      run_instr(16'h0400, 1'b1);   // branch taken (R10)
      run_instr(16'hE1FF, 1'b1);   // effective address (R9)
      run_instr(16'hC1C0, 1'b0);   // register jump (R11)
      run_instr(16'h4801, 1'b0);   // call, PC relative (R12)
      run_instr(16'h4080, 1'b0);   // call, base register (R12)
      run_instr(16'h2005, 1'b0);   // load (R6)
      run_instr(16'h6283, 1'b0);   // base load (R6, R8)
      run_instr(16'hA003, 1'b0);   // indirect load (R6)
      run_instr(16'h3003, 1'b0);   // store (R7)
      run_instr(16'h7283, 1'b0);   // base store (R7, R8)
      run_instr(16'hB003, 1'b0);   // indirect store (R7)
      run_instr(16'h8000, 1'b1);   // unimplemented (R13)
      run_instr(16'hD123, 1'b1);   // unimplemented (R13)
      run_instr(16'hF025, 1'b1);   // unimplemented (R13)
      // random mix
      for (int t = 0; t < 400; t++) begin
         run_instr(16'($urandom()), 1'($urandom()));
      end
      // R1: reset in the middle of an instruction
      ir = 16'hA003;
      @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_word("R1", '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_word("R1", expect_word(16'h0, 1'b0, 0));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule